// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a bus master for a three-wire serial EEPROM holding 64 sixteen-bit words. A host presents a 6-bit word address together with a one-cycle start pulse. The block then runs a complete read access on the serial pins. It raises chip select and shifts out a 9-bit command made of the read opcode and the address. It clocks in 16 data bits, then closes the access with a short termination sequence. At the end it presents the word on `rdata` together with a one-cycle `done` pulse.

Every serial clock level lasts a fixed number of system clock cycles, set by the parameter `HALF_CYC`. The default of 5000 gives a 40 µs half-period at a 125 MHz system clock. The serial data returned by the EEPROM passes through a two-flop synchroniser before it is used, so `HALF_CYC` must be at least 4. Only the read command is issued. A new access can start on the cycle after `done`.

Top module: `ee_word_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are low and `rdata` is zero. While no access runs, `ee_cs` and `ee_sk` stay low.
- R2: An access shifts out 9 command bits on `ee_di`, most significant first. The bits are binary 110 followed by the 6-bit address. Each bit is set while `ee_sk` is low and does not change while `ee_sk` is high.
- R3: After the command, 16 serial clock pulses read the data. Each bit of `ee_do` is taken near the end of a high phase and shifted into the low end of the result, so the first bit received becomes bit 15 of `rdata`.
- R4: `ee_cs` rises when the access starts and stays high for all 25 command and data clock pulses. It falls only during an access, while `ee_sk` is low.
- R5: After the last data bit, `ee_cs` goes low and exactly one more full `ee_sk` pulse is given with `ee_cs` low. That pulse is followed by one low half-period before `done`.
- R6: Every high and low level of `ee_sk` lasts `HALF_CYC` system cycles. `done` is high in the cycle that follows the clock edge lying 53×`HALF_CYC` cycles after the edge that accepted `start`.
- R7: A start pulse that arrives while `busy` is high is ignored. The running access keeps its address, its result and its timing, and no second access follows it.
- R8: `done` is high for exactly one cycle. `rdata` holds the result until the next access completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to read a word |
| addr | input | 6 | Word address, captured with `start` |
| busy | output | 1 | High while an access runs |
| done | output | 1 | One-cycle pulse when `rdata` is new |
| rdata | output | 16 | Last word read |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM (asynchronous) |

## Verification
The result of an access is due in the cycle that follows the edge lying 53 half-periods after the accepting edge: 18 for the command, 32 for the data, 2 for the trailing pulse and 1 for the last low level. The bench counts clock edges from the accepting edge and samples `done` on falling edges. It requires the first high `done` to appear at exactly 53×`HALF_CYC` edges, and it checks `rdata` there. One cycle later it checks that `done` has dropped and `rdata` is unchanged. A behavioural EEPROM in the bench reacts to `ee_sk` rising edges. It sets up each data bit a whole half-period before the block samples it, so the result does not depend on the synchroniser delay. The same model counts the command bits, the pulses with chip select high, and the pulses with chip select low.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

    localparam int          OPC_W     = 3;
    localparam logic [2:0]  RD_OPCODE = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_TERM,
        ST_TAIL
    } ee_state_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } ee_pins_t;

    localparam ee_pins_t PINS_OFF = '{cs: 1'b0, sk: 1'b0, di: 1'b0};

endpackage

// File: rtl/ee_half_timer.sv
module ee_half_timer #(
    parameter int HALF_CYC = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ee_sync2.sv
module ee_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ee_rd_seq.sv
module ee_rd_seq
    import ee_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tick,
    input  logic              do_s,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output ee_pins_t          pins
);
    localparam int CMD_W  = OPC_W + ADDR_W;
    localparam int MAX_W  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W  = $clog2(MAX_W);

    ee_state_e         state;
    logic [CMD_W-1:0]  cmd_sr;
    logic [DATA_W-1:0] data_sr;
    logic [CNT_W-1:0]  bitcnt;
    logic [CMD_W-1:0]  cmd_new;

    assign cmd_new = {RD_OPCODE, addr};
    assign busy    = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cmd_sr  <= '0;
            data_sr <= '0;
            bitcnt  <= '0;
            done    <= 1'b0;
            rdata   <= '0;
            pins    <= PINS_OFF;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_sr  <= cmd_new << 1;
                        pins.di <= cmd_new[CMD_W-1];
                        pins.cs <= 1'b1;
                        pins.sk <= 1'b0;
                        bitcnt  <= '0;
                        state   <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (tick) begin
                        if (!pins.sk) begin
                            pins.sk <= 1'b1;
                        end else begin
                            pins.sk <= 1'b0;
                            if (bitcnt == CNT_W'(CMD_W - 1)) begin
                                bitcnt  <= '0;
                                pins.di <= 1'b0;
                                state   <= ST_DATA;
                            end else begin
                                bitcnt  <= bitcnt + 1'b1;
                                pins.di <= cmd_sr[CMD_W-1];
                                cmd_sr  <= cmd_sr << 1;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        if (!pins.sk) begin
                            pins.sk <= 1'b1;
                        end else begin
                            pins.sk <= 1'b0;
                            data_sr <= {data_sr[DATA_W-2:0], do_s};
                            if (bitcnt == CNT_W'(DATA_W - 1)) begin
                                bitcnt  <= '0;
                                pins.cs <= 1'b0;
                                state   <= ST_TERM;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                end
                ST_TERM: begin
                    if (tick) begin
                        if (!pins.sk) begin
                            pins.sk <= 1'b1;
                        end else begin
                            pins.sk <= 1'b0;
                            state   <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        rdata <= data_sr;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
    import ee_rd_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int HALF_CYC = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    ee_pins_t pins;
    logic     tick;
    logic     do_s;

    ee_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    ee_sync2 #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ee_do),
        .q   (do_s)
    );

    ee_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .addr  (addr),
        .tick  (tick),
        .do_s  (do_s),
        .busy  (busy),
        .done  (done),
        .rdata (rdata),
        .pins  (pins)
    );

    assign ee_cs = pins.cs;
    assign ee_sk = pins.sk;
    assign ee_di = pins.di;
endmodule

// File: rtl/ee_word_reader_chk.sv
module ee_word_reader_chk #(
    parameter int HALF_CYC = 5000
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    localparam int SW = $clog2(HALF_CYC + 1) + 1;

    logic [SW-1:0] since;
    logic          sk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            sk_q  <= 1'b0;
        end else begin
            sk_q <= ee_sk;
            if (!busy) begin
                since <= '0;
            end else if (ee_sk != sk_q) begin
                since <= SW'(1);
            end else begin
                since <= since + 1'b1;
            end
        end
    end

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk));

    // R2
    di_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R4
    cs_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ee_cs) |-> (busy && !ee_sk));

    // R6
    half_period_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (ee_sk != sk_q)) |-> (since == SW'(HALF_CYC)));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind ee_word_reader ee_word_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ee_cs (ee_cs),
    .ee_sk (ee_sk),
    .ee_di (ee_di)
);

// File: tb/ee_word_reader_bench.sv
`timescale 1ns/1ps
module ee_word_reader_bench;
    localparam int H      = 4;
    localparam int LAT    = 53 * H;
    localparam int NVEC   = 8;
    localparam logic [21:0] VEC [NVEC] = '{
        {6'd0,  16'h0000}, {6'd63, 16'hFFFF}, {6'd21, 16'hAAAA},
        {6'd42, 16'h5555}, {6'd1,  16'h8001}, {6'd32, 16'h1234},
        {6'd7,  16'hFEDC}, {6'd56, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  addr = '0;
    logic        busy, done, ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ee_word_reader #(.HALF_CYC(H)) u_ee_word_reader (
        .clk(clk), .rst(rst), .start(start), .addr(addr),
        .busy(busy), .done(done), .rdata(rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // behavioural EEPROM
    logic [15:0] mem [64];
    logic [8:0]  r_cmd;
    logic [15:0] r_word;
    int r_edges = 0;
    int lo_pulses = 0;
    int cs_falls = 0;

    function automatic logic [15:0] fill(input int a);
        return 16'(a * 16'h0B17) ^ 16'h5A3C;
    endfunction

    always @(posedge ee_cs) r_edges = 0;
    always @(negedge ee_cs) cs_falls++;

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            r_edges++;
            if (r_edges <= 9) r_cmd = {r_cmd[7:0], ee_di};
            if (r_edges == 9) begin
                r_word = mem[r_cmd[5:0]];
                #1 ee_do = 1'b0;
            end else if (r_edges >= 10 && r_edges <= 25) begin
                #1 ee_do = r_word[25 - r_edges];
            end
        end else begin
            lo_pulses++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one read; optional second start while busy
    task automatic do_read(input logic [5:0] a, input logic [15:0] exp,
                           input bit mid, input logic [5:0] a2);
        int cyc;
        bit got;
        int lo0;
        int falls0;
        lo0 = lo_pulses;
        falls0 = cs_falls;
        @(negedge clk);
        addr = a;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        got = 0;
        while (!got && cyc < 4000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done) begin
                got = 1;
                start = 1'b0;
            end else begin
                start = mid && (cyc == 40);
                if (mid && cyc == 40) addr = a2;
            end
        end
        chk("R6", cyc, LAT, "done latency in cycles");
        chk("R3", rdata, exp, "read word");
        chk("R2", r_cmd, {3'b110, a}, "command frame");
        chk("R4", r_edges, 25, "clock pulses with cs high");
        chk("R5", lo_pulses - lo0, 1, "pulses with cs low");
        chk("R4", cs_falls - falls0, 1, "cs falls per access");
        @(negedge clk);
        chk("R8", done, 0, "done width");
        chk("R8", rdata, exp, "rdata held");
        chk("R1", {ee_cs, ee_sk, busy}, 0, "idle pins after access");
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = fill(i);
        for (int i = 0; i < NVEC; i++) mem[VEC[i][21:16]] = VEC[i][15:0];

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", ee_cs, 0, "cs after reset");
        chk("R1", ee_sk, 0, "sk after reset");
        chk("R1", ee_di, 0, "di after reset");
        chk("R1", busy, 0, "busy after reset");
        chk("R1", done, 0, "done after reset");
        chk("R1", rdata, 0, "rdata after reset");

        for (int i = 0; i < NVEC; i++) begin
            do_read(VEC[i][21:16], VEC[i][15:0], 1'b0, 6'd0);
        end

        // R7 start while busy is ignored
        do_read(6'd5, fill(5), 1'b1, 6'd9);
        repeat (3 * H) @(negedge clk);
        chk("R7", busy, 0, "no second access after ignored start");
        chk("R7", rdata, fill(5), "result kept after ignored start");

        // back-to-back access right after done
        do_read(6'd9, fill(9), 1'b0, 6'd0);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule